// File: doc/BRIEF.md
# Serial Byte Receiver with Bounded Waits

This block captures a single byte from one serial line that rests high when idle. A one-cycle arm strobe starts a capture. The block then watches the line for a falling level. Once it sees the line low, it waits half a bit time to reach the centre of the start bit. It then takes eight single samples, one bit time apart, and places the first sample in the least significant position.

After the eighth sample the block waits for the line to return high, which marks the stop bit. Each of its two waits, the one for the start level and the one for the stop level, is bounded. The bound is a poll interval times a poll count, both counted in clock cycles. If either wait runs out, the block raises a one-cycle error pulse, drops the partial byte, clears its shift register and goes back to idle. Another capture needs another arm strobe.

A completed byte leaves on a valid/ready output. The byte and its valid flag stay unchanged until the consumer takes them with ready. While a byte is waiting to be taken, every arm strobe is ignored, so data cannot be lost or overwritten. The line input passes through a two-stage synchroniser before the block looks at it.

Top module: `serial_byte_catcher`

## Requirements
- R1: After reset, `rx_valid_o` and `rx_err_o` are low and the block is idle. The line is ignored until an arm strobe is accepted.
- R2: If the line stays high after an accepted arm, `rx_err_o` goes high for exactly one cycle. It rises exactly POLL_CYC*POLL_MAX clock cycles after the edge that accepted the arm, and no byte is delivered.
- R3: A frame on the line consists of a low start bit, eight data bits with bit 0 sent first, and a high stop bit, each bit BIT_CYC cycles long. For such a frame, `rx_data_o` equals the eight data bits, with the first bit after the start bit in position 0.
- R4: After the eighth sample, if the line stays low for POLL_CYC*POLL_MAX cycles, `rx_err_o` pulses once and no byte is delivered.
- R5: A byte is presented only after a good stop level. `rx_valid_o` rises with it. While `rx_ready_i` is low, `rx_valid_o` stays high and `rx_data_o` stays stable. A transfer happens on a cycle where valid and ready are both high, and valid falls on the next cycle.
- R6: An arm strobe has no effect while a capture is in progress or while a delivered byte has not yet been taken.
- R7: After an error the block stays idle. Line activity without a new arm strobe produces neither a byte nor an error.
- R8: An error pulse and the rise of `rx_valid_o` never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | One-cycle strobe that starts a capture |
| line_i | input | 1 | Serial line, high when idle, asynchronous |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Byte available |
| rx_ready_i | input | 1 | Consumer accepts the byte |
| rx_err_o | output | 1 | One-cycle pulse when a wait times out |

## Verification
The assertions assume that `rx_ready_i` is a level the consumer drives freely. They also assume that `arm_i` is a strobe that may arrive at any time, including during a capture or while a byte is still waiting. The stimulus changes every input only on falling clock edges. It shapes each frame to whole bit times of BIT_CYC cycles, so that the centre samples land well inside each bit. It tests the stop-level timeout only with a byte whose last bit is zero, because a high last bit would itself satisfy the stop wait.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_START,
    ST_HALF,
    ST_DATA,
    ST_WAIT_HIGH
  } rx_state_t;
endpackage

// File: rtl/ubr_line_sync.sv
module ubr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  // Resets to the idle-high level so that no start is seen after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ubr_tick_timer.sv
module ubr_tick_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/serial_byte_catcher.sv
module serial_byte_catcher
  import ubr_pkg::*;
#(
  parameter int BIT_CYC  = 16,
  parameter int POLL_CYC = 4,
  parameter int POLL_MAX = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic       line_i,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  input  logic       rx_ready_i,
  output logic       rx_err_o
);
  localparam int TMAX     = (BIT_CYC > POLL_CYC) ? BIT_CYC : POLL_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int PW       = $clog2(POLL_MAX + 1);
  localparam int HALF_CYC = (BIT_CYC / 2 > 0) ? BIT_CYC / 2 : 1;
  localparam logic [TW-1:0] BIT_LD  = TW'(BIT_CYC - 1);
  localparam logic [TW-1:0] HALF_LD = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] POLL_LD = TW'(POLL_CYC - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);

  rx_state_t     state_q, state_d;
  logic [7:0]    shift_q, shift_d;
  logic [2:0]    bitc_q, bitc_d;
  logic [PW-1:0] poll_q, poll_d;
  logic [7:0]    data_q, data_d;
  logic          valid_q, valid_d;
  logic          err_q, err_d;
  logic          line_s, tmr_zero, tmr_load;
  logic [TW-1:0] tmr_val;

  ubr_line_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(line_i), .sync_o(line_s)
  );

  ubr_tick_timer #(.W(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
    .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    shift_d  = shift_q;
    bitc_d   = bitc_q;
    poll_d   = poll_q;
    data_d   = data_q;
    valid_d  = valid_q && !rx_ready_i;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = POLL_LD;
    unique case (state_q)
      ST_IDLE: begin
        if (arm_i && !valid_q) begin
          state_d  = ST_WAIT_START;
          poll_d   = '0;
          tmr_load = 1'b1;
        end
      end
      ST_WAIT_START, ST_WAIT_HIGH: begin
        if (state_q == ST_WAIT_START && !line_s) begin
          state_d  = ST_HALF;
          tmr_load = 1'b1;
          tmr_val  = HALF_LD;
        end else if (state_q == ST_WAIT_HIGH && line_s) begin
          state_d = ST_IDLE;
          data_d  = shift_q;
          valid_d = 1'b1;
        end else if (tmr_zero) begin
          if (poll_q == POLL_LAST) begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
            shift_d = '0;
          end else begin
            poll_d   = poll_q + 1'b1;
            tmr_load = 1'b1;
          end
        end
      end
      ST_HALF: begin
        if (tmr_zero) begin
          state_d  = ST_DATA;
          bitc_d   = '0;
          tmr_load = 1'b1;
          tmr_val  = BIT_LD;
        end
      end
      ST_DATA: begin
        if (tmr_zero) begin
          shift_d  = {line_s, shift_q[7:1]};
          bitc_d   = bitc_q + 1'b1;
          tmr_load = 1'b1;
          if (bitc_q == 3'd7) begin
            state_d = ST_WAIT_HIGH;
            poll_d  = '0;
            tmr_val = POLL_LD;
          end else begin
            tmr_val = BIT_LD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      bitc_q  <= '0;
      poll_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      shift_q <= shift_d;
      bitc_q  <= bitc_d;
      poll_q  <= poll_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign rx_data_o  = data_q;
  assign rx_valid_o = valid_q;
  assign rx_err_o   = err_q;

  p_err_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |=> !rx_err_o);

  p_poll_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_START || state_q == ST_WAIT_HIGH) |-> poll_q <= POLL_LAST);

  p_err_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |-> ($past(state_q) == ST_WAIT_START || $past(state_q) == ST_WAIT_HIGH));

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  p_arm_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> state_q == ST_IDLE);

  p_idle_after_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_o |-> (state_q == ST_IDLE && shift_q == 8'h00));

  p_no_err_with_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> !rx_err_o);
endmodule

// File: tb/serial_byte_catcher_tb_top.sv
module serial_byte_catcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT = 16;
  localparam int PC  = 4;
  localparam int PM  = 8;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic line = 1'b1;
  logic ready = 1'b1;
  logic [7:0] data;
  logic valid, err;

  int checks = 0;
  int fails = 0;
  int events_seen = 0;
  bit done = 1'b0;
  logic [8:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_byte_catcher #(.BIT_CYC(BIT), .POLL_CYC(PC), .POLL_MAX(PM)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .line_i(line),
    .rx_data_o(data), .rx_valid_o(valid), .rx_ready_i(ready), .rx_err_o(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm_pulse();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  // Drives one frame; stop_ok=0 holds the line low past the stop timeout.
  task automatic send_frame(input logic [7:0] b, input bit stop_ok);
    line = 1'b0;
    tick(BIT);
    for (int i = 0; i < 8; i++) begin
      line = b[i];
      tick(BIT);
    end
    if (stop_ok) begin
      line = 1'b1;
      tick(2*BIT);
    end else begin
      line = 1'b0;
      tick(PC*PM + 2*BIT);
      line = 1'b1;
      tick(BIT);
    end
  endtask

  task automatic rx_byte(input logic [7:0] b);
    expq.push_back({1'b0, b});
    arm_pulse();
    tick(3);
    send_frame(b, 1'b1);
  endtask

  // Scoreboard monitor: every handshake or error pops one expected item.
  always @(negedge clk) begin
    if (rst_n && ((valid && ready) || err)) begin
      events_seen++;
      if (expq.size() == 0) begin
        check(1'b0, "R6/R7 unexpected event", {err, data}, 0);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        if (e[8]) check(err && !valid, "R2/R4 error expected", {err, valid}, 2);
        else      check(!err && data == e[7:0], "R3/R5 byte", {err, data}, e[7:0]);
      end
    end
  end

  initial begin
    int cnt;
    int seen0;
    logic [7:0] held;
    tick(3);
    // R1: reset state
    check(valid == 1'b0, "R1 valid after reset", valid, 0);
    check(err == 1'b0, "R1 err after reset", err, 0);
    rst_n = 1'b1;
    tick(2);
    line = 1'b0; tick(BIT); line = 1'b1; tick(BIT);
    check(events_seen == 0, "R1 line ignored before arm", events_seen, 0);

    // R2: start timeout exact timing
    expq.push_back(9'h100);
    arm_pulse();
    cnt = 0;
    while (!err && cnt < PC*PM + 20) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == PC*PM, "R2 start timeout cycles", cnt, PC*PM);
    @(negedge clk);
    check(err == 1'b0, "R2 err single cycle", err, 0);
    tick(4);

    // R3: several patterns
    rx_byte(8'hA5);
    rx_byte(8'h00);
    rx_byte(8'hFF);
    rx_byte(8'h3C);
    rx_byte(8'h81);

    // R4: stop-level timeout with last bit zero
    expq.push_back(9'h100);
    arm_pulse();
    tick(3);
    send_frame(8'h12, 1'b0);
    check(expq.size() == 0, "R4 stop timeout reported", expq.size(), 0);

    // R7: activity without arm after an error yields nothing
    seen0 = events_seen;
    send_frame(8'h55, 1'b1);
    check(events_seen == seen0, "R7 idle after error", events_seen, seen0);

    // R5/R6: back-pressure, arm ignored while byte pending
    ready = 1'b0;
    arm_pulse();
    tick(3);
    send_frame(8'hC3, 1'b1);
    check(valid == 1'b1, "R5 valid held", valid, 1);
    held = data;
    check(held == 8'hC3, "R5 held byte", held, 8'hC3);
    arm_pulse();
    tick(PC*PM + 10);
    check(valid == 1'b1 && data == held, "R5 stable under back-pressure", data, held);
    check(events_seen == seen0, "R6 arm ignored while pending", events_seen, seen0);
    expq.push_back({1'b0, 8'hC3});
    ready = 1'b1;
    tick(2);
    check(valid == 1'b0, "R5 valid drops after transfer", valid, 0);

    // R6: arm during capture ignored
    expq.push_back({1'b0, 8'h6E});
    arm_pulse();
    tick(3);
    line = 1'b0;
    tick(BIT);
    arm = 1'b1; tick(1); arm = 1'b0;
    for (int i = 0; i < 8; i++) begin
      line = 8'h6E >> i;
      tick(BIT - ((i == 0) ? 1 : 0));
    end
    line = 1'b1;
    tick(PC*PM + 2*BIT);
    check(expq.size() == 0, "R6/R8 capture completes once", expq.size(), 0);

    check(expq.size() == 0, "R3 scoreboard drained", expq.size(), 0);
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < WATCHDOG) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", n, WATCHDOG);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule